// File: doc/BRIEF.md
# Debug Trigger Arbiter and Sequencer

This block sits beside a set of address comparators and the CPU in an on-chip debug subsystem. Each cycle it takes four comparator match channels and the CPU's reports that a tagged instruction has reached execution. It picks one winning trigger per cycle and uses it to step a small sequencer through up to three intermediate states toward a final state. Software programs a next-state routing word for each intermediate state. It also controls arming, trace alignment, a range mode and breakpoint enabling, and it can force a trigger directly through a control write.

Once the final state is reached, the block does one of two things. Under end alignment it disarms at once. Under begin or mid alignment it raises a trace-start signal and waits for the trace logic to report completion. Breakpoint requests go out as one-cycle pulses whenever a session ends through hardware and breakpoints are enabled. Software can read back the winning source and the current state through the same register port.

Register map (word address): 0 = control/status, 1..3 = routing word for intermediate states 1..3. A routing word holds one 4-bit code per channel, with channel i at bits [4i+3:4i].

Top module: `dbg_trig_ctrl`

## Requirements
- R1: After a synchronous reset, `armed`, `trace_start`, `bkpt_req` and `reg_rdata` are 0, and the status word and all routing words read 0.
- R2: Writing address 0 with bit0=1 and bit1=0 arms the block, puts it in state 1 and clears the source flags. This applies even when the block is already armed. Bits [3:2] store alignment (00 begin, 01 mid, 1x end), bit4 stores range mode and bit5 stores breakpoint enable on every address-0 write.
- R3: While the block is armed in state s (1..3), a forced match or tag hit on channel i moves it, at the next edge, to the state given by code i of routing word s (1..3 = that state, 4 = final). Status bits [14:9] then hold {software, tag, channel one-hot}. The tag bit is set only when the channel had a tag hit and no forced match.
- R4: Routing codes 0 and 5..15 cause no transition. While disarmed, match and tag inputs have no effect.
- R5: When several channels with valid codes fire together, the lowest channel number wins.
- R6: A firing channel whose code is 4 (final) wins over every other coincident channel, even lower-numbered ones.
- R7: In range mode, channel 2 is suppressed whenever channel 0 fires. Channel 2 firing alone still acts.
- R8: Under end alignment, reaching the final state by a match clears `armed` at the same edge and leaves the state at 4. If breakpoints are enabled, `bkpt_req` pulses for exactly one cycle.
- R9: Under begin or mid alignment, reaching the final state sets `trace_start` and keeps the block armed. A later `trace_done` clears both and pulses `bkpt_req` if breakpoints are enabled.
- R10: Writing address 0 with bit1=1 while armed in states 1..3 under begin or mid alignment moves the block to state 4 with `trace_start` high and source flags 6'b100000. Any breakpoint waits for `trace_done`.
- R11: The same trigger write under end alignment disarms the block, returns it to state 0 and pulses `bkpt_req` at once if breakpoints are enabled.
- R12: An arming write in the same cycle as a hardware disarm (an end-alignment final transition, or `trace_done` in the final state) leaves `armed` at 0.
- R13: Writing address 0 with bit0=0 and bit1=0 disarms the block, returns it to state 0 and clears `trace_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmatch | input | N_CH | Forced comparator match per channel |
| tag_hit | input | N_CH | Tagged-instruction execution hit per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | N_CH*NIB_W | Register write data |
| reg_rdata | output | N_CH*NIB_W | Registered read data for `reg_addr` |
| trace_done | input | 1 | Trace logic reports completion |
| armed | output | 1 | Session armed |
| trace_start | output | 1 | Final state reached, tracing to complete |
| bkpt_req | output | 1 | One-cycle breakpoint request |

## Verification
Two things can land in the same cycle: a software arming write and a hardware disarm. The hardware disarm comes either from a match that routes to the final state under end alignment, or from `trace_done` while trace is pending. The bench drives the write strobe and the match, or `trace_done`, on the same clock edge, and it passes only if `armed` reads 0 right after that edge. A control case, in which the same arming write lands without a concurrent trigger, must leave the block armed. Coincident channel matches are also driven in table rows, and the winner is judged from the status state and source fields.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int          N_MID    = 3;
  localparam int          ST_W     = 3;
  localparam logic [2:0]  ST_IDLE  = 3'd0;
  localparam logic [2:0]  ST_FINAL = 3'd4;
  localparam int          STAT_ST  = 6;
  localparam int          STAT_SRC = 9;

  function automatic logic st_is_mid(input logic [2:0] s);
    return (s != ST_IDLE) && (s < ST_FINAL);
  endfunction
endpackage

// File: rtl/dbg_trig_pick.sv
module dbg_trig_pick #(
  parameter int N_CH  = 4,
  parameter int NIB_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    range_en,
  input  logic [N_CH-1:0]         fmatch,
  input  logic [N_CH-1:0]         tag_hit,
  input  logic [N_CH*NIB_W-1:0]   route,
  output logic                    fire,
  output logic [N_CH-1:0]         win_ch,
  output logic                    win_tag,
  output logic [2:0]              win_next
);
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0] act, ok, fin;
  logic [2:0]      nxt [N_CH];
  logic [IW-1:0]   sel;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [NIB_W-1:0] nib;
    logic             sup;
    assign nib = route[g*NIB_W +: NIB_W];
    if (g == 2) begin : g_fold
      assign sup = range_en & (fmatch[0] | tag_hit[0]);
    end else begin : g_nofold
      assign sup = 1'b0;
    end
    assign act[g] = enable & (fmatch[g] | tag_hit[g]) & ~sup;
    assign ok[g]  = act[g] && (nib >= NIB_W'(1)) && (nib <= NIB_W'(4));
    assign fin[g] = act[g] && (nib == NIB_W'(4));
    assign nxt[g] = ok[g] ? nib[2:0] : 3'd0;
  end

  always_comb begin
    sel = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (ok[i]) sel = IW'(i);
    for (int i = N_CH - 1; i >= 0; i--)
      if (fin[i]) sel = IW'(i);
    win_ch = '0;
    if (|ok) win_ch[sel] = 1'b1;
    fire     = |ok;
    win_tag  = tag_hit[sel] & ~fmatch[sel];
    win_next = nxt[sel];
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_ch) && (fire == (win_ch != '0)));                    // R5
  AST_RANGE_FOLD: assert property (@(posedge clk) disable iff (rst)
    (range_en && (fmatch[0] || tag_hit[0])) |-> !win_ch[2]);          // R7
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !fire);                                               // R4
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_arm_set,
  input  logic              wr_arm_clr,
  input  logic              wr_trig,
  input  logic              align_end,
  input  logic              bk_en,
  input  logic              fire,
  input  logic [N_CH-1:0]   win_ch,
  input  logic              win_tag,
  input  logic [2:0]        win_next,
  input  logic              trace_done,
  output logic [2:0]        state_q,
  output logic              arm_q,
  output logic              trc_q,
  output logic              bkpt_q,
  output logic [N_CH+1:0]   src_q
);
  logic mid, trig_act, fire_act, to_fin, done_act, hw_dis;

  assign mid      = st_is_mid(state_q);
  assign trig_act = arm_q & mid & wr_trig;
  assign fire_act = arm_q & mid & fire & ~wr_trig;
  assign to_fin   = fire_act & (win_next == ST_FINAL);
  assign done_act = arm_q & (state_q == ST_FINAL) & trc_q & trace_done;
  assign hw_dis   = ((trig_act | to_fin) & align_end) | done_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      arm_q   <= 1'b0;
      trc_q   <= 1'b0;
      bkpt_q  <= 1'b0;
      src_q   <= '0;
    end else begin
      bkpt_q <= 1'b0;
      if (wr_arm_clr) begin
        arm_q   <= 1'b0;
        state_q <= ST_IDLE;
        trc_q   <= 1'b0;
      end else if (wr_arm_set && !hw_dis) begin
        arm_q   <= 1'b1;
        state_q <= 3'd1;
        trc_q   <= 1'b0;
        src_q   <= '0;
      end else if (trig_act) begin
        src_q <= {1'b1, 1'b0, {N_CH{1'b0}}};
        if (align_end) begin
          arm_q   <= 1'b0;
          state_q <= ST_IDLE;
          bkpt_q  <= bk_en;
        end else begin
          state_q <= ST_FINAL;
          trc_q   <= 1'b1;
        end
      end else if (fire_act) begin
        state_q <= win_next;
        src_q   <= {1'b0, win_tag, win_ch};
        if (to_fin) begin
          if (align_end) begin
            arm_q  <= 1'b0;
            bkpt_q <= bk_en;
          end else begin
            trc_q <= 1'b1;
          end
        end
      end else if (done_act) begin
        arm_q  <= 1'b0;
        trc_q  <= 1'b0;
        bkpt_q <= bk_en;
      end
    end
  end

  AST_BKPT_PULSE: assert property (@(posedge clk) disable iff (rst)
    bkpt_q |=> !bkpt_q);                                              // R8
  AST_TRACE_ARMED: assert property (@(posedge clk) disable iff (rst)
    trc_q |-> (arm_q && state_q == ST_FINAL));                        // R9
  AST_HW_DISARM_WINS: assert property (@(posedge clk) disable iff (rst)
    hw_dis |=> !arm_q);                                               // R12
  AST_IDLE_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !arm_q);                                 // R13
endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int NIB_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_CH-1:0]         fmatch,
  input  logic [N_CH-1:0]         tag_hit,
  input  logic                    reg_we,
  input  logic [1:0]              reg_addr,
  input  logic [N_CH*NIB_W-1:0]   reg_wdata,
  output logic [N_CH*NIB_W-1:0]   reg_rdata,
  input  logic                    trace_done,
  output logic                    armed,
  output logic                    trace_start,
  output logic                    bkpt_req
);
  localparam int DW = N_CH * NIB_W;

  logic [1:0]       cfg_align;
  logic             cfg_range, cfg_bken;
  logic [DW-1:0]    route_q [N_MID];
  logic [DW-1:0]    cur_route, stat;
  logic             ctl_wr, wr_trig, wr_arm_set, wr_arm_clr;
  logic             fire, win_tag;
  logic [N_CH-1:0]  win_ch;
  logic [2:0]       win_next, state_q;
  logic [N_CH+1:0]  src_q;

  assign ctl_wr     = reg_we && (reg_addr == 2'd0);
  assign wr_trig    = ctl_wr &  reg_wdata[1];
  assign wr_arm_set = ctl_wr &  reg_wdata[0] & ~reg_wdata[1];
  assign wr_arm_clr = ctl_wr & ~reg_wdata[0] & ~reg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_align <= 2'b00;
      cfg_range <= 1'b0;
      cfg_bken  <= 1'b0;
    end else if (ctl_wr) begin
      cfg_align <= reg_wdata[3:2];
      cfg_range <= reg_wdata[4];
      cfg_bken  <= reg_wdata[5];
    end
  end

  for (genvar r = 0; r < N_MID; r++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst) route_q[r] <= '0;
      else if (reg_we && reg_addr == 2'(r + 1)) route_q[r] <= reg_wdata;
    end
  end

  always_comb begin
    cur_route = '0;
    for (int s = 0; s < N_MID; s++)
      if (state_q == 3'(s + 1)) cur_route = route_q[s];
  end

  dbg_trig_pick #(.N_CH(N_CH), .NIB_W(NIB_W)) u_pick (
    .clk(clk), .rst(rst),
    .enable(armed & st_is_mid(state_q)), .range_en(cfg_range),
    .fmatch(fmatch), .tag_hit(tag_hit), .route(cur_route),
    .fire(fire), .win_ch(win_ch), .win_tag(win_tag), .win_next(win_next)
  );

  dbg_trig_seq #(.N_CH(N_CH)) u_seq (
    .clk(clk), .rst(rst),
    .wr_arm_set(wr_arm_set), .wr_arm_clr(wr_arm_clr), .wr_trig(wr_trig),
    .align_end(cfg_align[1]), .bk_en(cfg_bken),
    .fire(fire), .win_ch(win_ch), .win_tag(win_tag), .win_next(win_next),
    .trace_done(trace_done),
    .state_q(state_q), .arm_q(armed), .trc_q(trace_start),
    .bkpt_q(bkpt_req), .src_q(src_q)
  );

  always_comb begin
    stat = '0;
    stat[0]                   = armed;
    stat[1]                   = trace_start;
    stat[3:2]                 = cfg_align;
    stat[4]                   = cfg_range;
    stat[5]                   = cfg_bken;
    stat[STAT_ST +: ST_W]     = state_q;
    stat[STAT_SRC +: N_CH+2]  = src_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                  reg_rdata <= '0;
    else if (reg_addr == 2'd0) reg_rdata <= stat;
    else                      reg_rdata <= route_q[reg_addr - 2'd1];
  end

  AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (!armed && !reg_we) |=> $stable(state_q));                        // R4
endmodule

// File: tb/dbg_trig_ctrl_bench.sv
module dbg_trig_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  fmatch = '0, tag_hit = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        trace_done = 1'b0;
  logic        armed, trace_start, bkpt_req;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] rd;

  always #5 clk = ~clk;

  dbg_trig_ctrl u_dbg_trig_ctrl (
    .clk(clk), .rst(rst), .fmatch(fmatch), .tag_hit(tag_hit),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trace_done(trace_done),
    .armed(armed), .trace_start(trace_start), .bkpt_req(bkpt_req)
  );

  typedef struct packed {
    logic [15:0] route;
    logic [3:0]  fm;
    logic [3:0]  tg;
    logic        rng;
    logic [2:0]  st;
    logic [5:0]  src;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{16'h0002, 4'b0001, 4'b0000, 1'b0, 3'd2, 6'b000001, 4'd3},  // R3 forced
    '{16'h0030, 4'b0000, 4'b0010, 1'b0, 3'd3, 6'b010010, 4'd3},  // R3 tag
    '{16'h3210, 4'b0001, 4'b0000, 1'b0, 3'd1, 6'b000000, 4'd4},  // R4 code 0
    '{16'h00F0, 4'b0010, 4'b0000, 1'b0, 3'd1, 6'b000000, 4'd4},  // R4 code 15
    '{16'h3322, 4'b1111, 4'b0000, 1'b0, 3'd2, 6'b000001, 4'd5},  // R5
    '{16'h3320, 4'b1110, 4'b0000, 1'b0, 3'd2, 6'b000010, 4'd5},  // R5
    '{16'h4322, 4'b1111, 4'b0000, 1'b0, 3'd4, 6'b001000, 4'd6},  // R6
    '{16'h0403, 4'b0101, 4'b0000, 1'b0, 3'd4, 6'b000100, 4'd6},  // R6
    '{16'h0403, 4'b0101, 4'b0000, 1'b1, 3'd3, 6'b000001, 4'd7},  // R7 folded
    '{16'h0403, 4'b0100, 4'b0000, 1'b1, 3'd4, 6'b000100, 4'd7},  // R7 alone
    '{16'h0002, 4'b0001, 4'b0001, 1'b0, 3'd2, 6'b000001, 4'd3},  // R3 both
    '{16'h0002, 4'b0000, 4'b0000, 1'b0, 3'd1, 6'b000000, 4'd4}   // R4 none
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd_reg(input logic [1:0] a);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk); @(posedge clk); #1;
    rd = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic pulse_in(input logic [3:0] fm, input logic [3:0] tg, input logic td);
    @(negedge clk);
    fmatch = fm; tag_hit = tg; trace_done = td;
    @(posedge clk); #1;
    fmatch = '0; tag_hit = '0; trace_done = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 armed", armed, 0);
    chk("R1 trace_start", trace_start, 0);
    chk("R1 bkpt_req", bkpt_req, 0);
    chk("R1 rdata", reg_rdata, 0);
    rd_reg(2'd0); chk("R1 status", rd, 0);
    rd_reg(2'd2); chk("R1 route", rd, 0);

    // table of coincidence and routing vectors
    foreach (VEC[k]) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[k].rq, k);
      wr(2'd1, VEC[k].route);
      wr(2'd0, {11'd0, VEC[k].rng, 4'b0001});
      pulse_in(VEC[k].fm, VEC[k].tg, 1'b0);
      rd_reg(2'd0);
      chk({tag, " state"}, rd[8:6], VEC[k].st);
      chk({tag, " src"}, rd[14:9], VEC[k].src);
    end

    // R2 restart while armed clears flags
    wr(2'd1, 16'h0002);
    wr(2'd0, 16'h0001);
    pulse_in(4'b0001, 4'b0000, 1'b0);
    wr(2'd0, 16'h0001);
    rd_reg(2'd0);
    chk("R2 restart state", rd[8:6], 1);
    chk("R2 restart src", rd[14:9], 0);
    chk("R2 armed", armed, 1);

    // R13 software disarm, then R4 inputs ignored while disarmed
    pulse_in(4'b0001, 4'b0000, 1'b0);
    wr(2'd0, 16'h0000);
    chk("R13 armed", armed, 0);
    rd_reg(2'd0); chk("R13 state", rd[8:6], 0);
    pulse_in(4'b1111, 4'b1111, 1'b0);
    rd_reg(2'd0); chk("R4 disarmed state", rd[8:6], 0);
    chk("R4 disarmed armed", armed, 0);

    // R8 end alignment final with breakpoint
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h0029);
    pulse_in(4'b0001, 4'b0000, 1'b0);
    chk("R8 armed", armed, 0);
    chk("R8 bkpt", bkpt_req, 1);
    @(posedge clk); #1;
    chk("R8 bkpt one cycle", bkpt_req, 0);
    rd_reg(2'd0); chk("R8 state", rd[8:6], 4);

    // R9 begin alignment final then trace_done
    wr(2'd0, 16'h0021);
    pulse_in(4'b0001, 4'b0000, 1'b0);
    chk("R9 trace_start", trace_start, 1);
    chk("R9 armed", armed, 1);
    chk("R9 no bkpt yet", bkpt_req, 0);
    pulse_in(4'b0000, 4'b0000, 1'b1);
    chk("R9 done armed", armed, 0);
    chk("R9 done trace_start", trace_start, 0);
    chk("R9 done bkpt", bkpt_req, 1);

    // R10 immediate trigger under mid alignment
    wr(2'd0, 16'h0025);
    wr(2'd0, 16'h0026);
    chk("R10 trace_start", trace_start, 1);
    chk("R10 armed", armed, 1);
    chk("R10 bkpt waits", bkpt_req, 0);
    rd_reg(2'd0);
    chk("R10 state", rd[8:6], 4);
    chk("R10 src", rd[14:9], 6'b100000);
    pulse_in(4'b0000, 4'b0000, 1'b1);
    chk("R10 bkpt after done", bkpt_req, 1);

    // R11 immediate trigger under end alignment
    wr(2'd0, 16'h0029);
    wr(2'd0, 16'h002A);
    chk("R11 armed", armed, 0);
    chk("R11 bkpt", bkpt_req, 1);
    rd_reg(2'd0); chk("R11 state", rd[8:6], 0);

    // R12 arm write vs end-final disarm in the same cycle
    wr(2'd0, 16'h0009);
    wr(2'd0, 16'h0009);
    chk("R2 rearm no conflict", armed, 1);
    @(negedge clk);
    fmatch = 4'b0001; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0009;
    @(posedge clk); #1;
    fmatch = '0; reg_we = 1'b0;
    chk("R12 end final", armed, 0);

    // R12 arm write vs trace_done disarm in the same cycle
    wr(2'd0, 16'h0001);
    pulse_in(4'b0001, 4'b0000, 1'b0);
    chk("R12 setup trace_start", trace_start, 1);
    @(negedge clk);
    trace_done = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001;
    @(posedge clk); #1;
    trace_done = 1'b0; reg_we = 1'b0;
    chk("R12 trace_done armed", armed, 0);
    chk("R12 trace_done trace_start", trace_start, 0);

    finish_run();
  end
endmodule